// File: doc/BRIEF.md
# Instruction Byte Queue with Busy Level Output

This block sits between a serial byte receiver and an instruction execution engine. Every byte the receiver delivers goes into a first-in first-out store. The execution engine drains that store in arrival order. The store holds 256 bytes so that a host can send a full burst of that size between two status polls without losing data.

Alongside the queue, the block drives a single busy level onto the serial output line while no read transfer is using that line. The level rises one clock after any byte is offered, whether or not that byte is stored. It stays high while the queue holds data, while a separate trace store reports that it is not empty, or while a debug monitor is active. It falls only when all of these conditions have cleared.

The receiver side is a valid/ready stream. `in_ready` is low exactly when the queue is full. A serial receiver cannot be stalled, so a byte offered while `in_ready` is low is discarded and latches a sticky overflow flag. The execution side is also valid/ready. `out_valid` is high whenever a byte is held, and `out_data` keeps its value until the consumer takes it by raising `out_ready`. A synchronous reset, active high, empties the queue and drives the level to ready.

Top module: `instr_byte_queue`

## Requirements
- R1: While `rst` is high at a clock edge, the queue becomes empty. After that edge `out_valid`=0, `in_ready`=1, `busy_level`=0 and `overflow`=0.
- R2: Bytes leave on `out_data` in exactly the order they were accepted.
- R3: `in_ready` is 0 exactly when 256 bytes are held. `out_valid` is 1 exactly when at least one byte is held.
- R4: A byte offered while `in_ready`=0 is discarded and the stored contents are unchanged. `overflow` becomes 1 after that edge and stays 1 until a reset.
- R5: `busy_level` is 1 in the cycle after any cycle with `in_valid`=1, whether or not the byte was accepted.
- R6: `busy_level` is 1 in every cycle in which `out_valid` is 1.
- R7: `busy_level` is 1 in the cycle after any cycle with `trace_empty`=0.
- R8: `busy_level` is 1 in the cycle after any cycle with `debug_active`=1.
- R9: After a cycle with `in_valid`=0, `trace_empty`=1 and `debug_active`=0, in which the queue is empty or its last byte is taken, `busy_level` is 0 (ready). 1 means busy and 0 means ready.
- R10: While `out_valid`=1 and `out_ready`=0, the next cycle still has `out_valid`=1 with `out_data` unchanged.
- R11: A push and a pop in the same cycle on a non-empty, non-full queue leave the held count unchanged and keep the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Receiver offers a byte |
| in_ready | output | 1 | Queue has room; low when full |
| in_data | input | 8 | Offered byte |
| out_valid | output | 1 | A byte is available to the engine |
| out_ready | input | 1 | Engine takes the byte this cycle |
| out_data | output | 8 | Oldest held byte |
| trace_empty | input | 1 | Trace store reports empty |
| debug_active | input | 1 | Debug monitor is running |
| busy_level | output | 1 | Serial status level: 1 busy, 0 ready |
| overflow | output | 1 | Sticky flag for a dropped byte |

## Verification
The bench builds the block with its default parameters: 8-bit data and a depth of 256. At this size the full boundary can be reached directly, so the bench fills all 256 slots, offers one extra byte against a full queue, and then drains everything to confirm that the extra byte never appeared. The same defaults let the bench watch the level fall on the exact cycle the final byte leaves. It also holds the level high from the trace input and the debug input alone, with the queue empty.

// File: rtl/ibq_pkg.sv
package ibq_pkg;

  typedef enum logic {
    LVL_READY = 1'b0,
    LVL_BUSY  = 1'b1
  } line_level_e;

  // Pointers carry one extra wrap bit above the index.
  // Equal index plus differing wrap bits means the store is full.
  function automatic logic wrap_full(input logic wr_wrap,
                                     input logic rd_wrap,
                                     input logic idx_same);
    return idx_same && (wr_wrap != rd_wrap);
  endfunction

endpackage

// File: rtl/ibq_store.sv
module ibq_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int SLOTS = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [SLOTS];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/ibq_ptrs.sv
module ibq_ptrs
  import ibq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic              pop_req,
  output logic              push_ok,
  output logic              pop_ok,
  output logic              full,
  output logic              empty,
  output logic              empty_next,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int PTR_W = ADDR_W + 1;

  logic [PTR_W-1:0] wr_q, rd_q, wr_n, rd_n;

  assign empty   = (wr_q == rd_q);
  assign full    = wrap_full(wr_q[ADDR_W], rd_q[ADDR_W],
                             wr_q[ADDR_W-1:0] == rd_q[ADDR_W-1:0]);
  assign push_ok = push_req && !full;
  assign pop_ok  = pop_req && !empty;

  always_comb begin
    wr_n = wr_q + PTR_W'(push_ok);
    rd_n = rd_q + PTR_W'(pop_ok);
  end

  assign empty_next = (wr_n == rd_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_n;
      rd_q <= rd_n;
    end
  end

  assign wr_addr = wr_q[ADDR_W-1:0];
  assign rd_addr = rd_q[ADDR_W-1:0];
endmodule

// File: rtl/ibq_status.sv
module ibq_status
  import ibq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic byte_seen,
  input  logic drop,
  input  logic queue_empty_next,
  input  logic trace_empty,
  input  logic debug_active,
  output logic busy_level,
  output logic overflow
);
  line_level_e lvl_q, lvl_d;
  logic        ovf_q;

  always_comb begin
    lvl_d = LVL_READY;
    if (byte_seen || !queue_empty_next || !trace_empty || debug_active)
      lvl_d = LVL_BUSY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= LVL_READY;
      ovf_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      if (drop) ovf_q <= 1'b1;
    end
  end

  assign busy_level = (lvl_q == LVL_BUSY);
  assign overflow   = ovf_q;
endmodule

// File: rtl/instr_byte_queue.sv
module instr_byte_queue #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic              trace_empty,
  input  logic              debug_active,
  output logic              busy_level,
  output logic              overflow
);
  localparam int ADDR_W = $clog2(DEPTH);

  logic              push_ok, pop_ok, full, empty, empty_next;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  ibq_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
    .clk        (clk),
    .rst        (rst),
    .push_req   (in_valid),
    .pop_req    (out_ready),
    .push_ok    (push_ok),
    .pop_ok     (pop_ok),
    .full       (full),
    .empty      (empty),
    .empty_next (empty_next),
    .wr_addr    (wr_addr),
    .rd_addr    (rd_addr)
  );

  ibq_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .wr_en   (push_ok),
    .wr_addr (wr_addr),
    .wr_data (in_data),
    .rd_addr (rd_addr),
    .rd_data (out_data)
  );

  ibq_status u_status (
    .clk              (clk),
    .rst              (rst),
    .byte_seen        (in_valid),
    .drop             (in_valid && full),
    .queue_empty_next (empty_next),
    .trace_empty      (trace_empty),
    .debug_active     (debug_active),
    .busy_level       (busy_level),
    .overflow         (overflow)
  );

  assign in_ready  = !full;
  assign out_valid = !empty;

  logic unused_pop;
  assign unused_pop = pop_ok;
endmodule

// File: rtl/instr_byte_queue_chk.sv
module instr_byte_queue_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              trace_empty,
  input logic              debug_active,
  input logic              busy_level,
  input logic              overflow
);
  // R5
  arrival_busy_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> busy_level);

  // R6
  held_busy_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy_level);

  // R7
  trace_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !trace_empty |=> busy_level);

  // R8
  debug_busy_chk: assert property (@(posedge clk) disable iff (rst)
    debug_active |=> busy_level);

  // R9
  idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !out_valid && trace_empty && !debug_active) |=> !busy_level);

  // R4
  sticky_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R4
  drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> overflow);

  // R10
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind instr_byte_queue instr_byte_queue_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .trace_empty  (trace_empty),
  .debug_active (debug_active),
  .busy_level   (busy_level),
  .overflow     (overflow)
);

// File: tb/sim_instr_byte_queue.sv
`timescale 1ns/1ps
module sim_instr_byte_queue;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic       trace_empty = 1'b1, debug_active = 1'b0;
  logic       in_ready, out_valid, busy_level, overflow;
  logic [7:0] out_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  instr_byte_queue u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .trace_empty(trace_empty),
    .debug_active(debug_active), .busy_level(busy_level), .overflow(overflow)
  );

  always #10 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    trace_empty = 1'b1; debug_active = 1'b0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(busy_level == 1'b0, "R1 busy_level", busy_level, 0);
    chk(overflow == 1'b0, "R1 overflow", overflow, 0);
  endtask

  task automatic t_order();
    logic [7:0] vals [5] = '{8'h3C, 8'hA5, 8'h00, 8'hFF, 8'h71};
    do_reset();
    for (int i = 0; i < 5; i++) begin
      in_valid = 1'b1; in_data = vals[i];
      tick();
      if (i == 0) chk(busy_level == 1'b1, "R5 busy after byte", busy_level, 1);
    end
    in_valid = 1'b0;
    tick();
    chk(busy_level == 1'b1, "R6 busy while held", busy_level, 1);
    out_ready = 1'b1;
    for (int i = 0; i < 5; i++) begin
      chk(out_valid && out_data == vals[i], "R2 order", out_data, vals[i]);
      tick();
    end
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R3 empty after drain", out_valid, 0);
    chk(busy_level == 1'b0, "R9 ready after drain", busy_level, 0);
  endtask

  task automatic t_hold();
    do_reset();
    in_valid = 1'b1; in_data = 8'h5A;
    tick();
    in_valid = 1'b1; in_data = 8'h6B;
    tick();
    in_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk(out_valid && out_data == 8'h5A, "R10 hold", out_data, 8'h5A);
    end
    out_ready = 1'b1;
    tick();
    out_ready = 1'b0;
    chk(out_data == 8'h6B, "R10 advance", out_data, 8'h6B);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < 256; i++) begin
      in_valid = 1'b1; in_data = 8'(i * 7 + 3);
      tick();
      if (i == 254) chk(in_ready == 1'b1, "R3 ready at 255", in_ready, 1);
    end
    chk(in_ready == 1'b0, "R3 full at 256", in_ready, 0);
    chk(overflow == 1'b0, "R4 no drop yet", overflow, 0);
    in_data = 8'hEE;
    tick();
    in_valid = 1'b0;
    chk(overflow == 1'b1, "R4 overflow set", overflow, 1);
    chk(busy_level == 1'b1, "R5 busy on dropped byte", busy_level, 1);
    out_ready = 1'b1;
    for (int i = 0; i < 256; i++) begin
      chk(out_valid && out_data == 8'(i * 7 + 3), "R4 contents kept", out_data, 8'(i * 7 + 3));
      tick();
    end
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R4 extra byte discarded", out_valid, 0);
    chk(overflow == 1'b1, "R4 overflow sticky", overflow, 1);
    chk(busy_level == 1'b0, "R9 ready after full drain", busy_level, 0);
    do_reset();
    chk(overflow == 1'b0, "R1 reset clears overflow", overflow, 0);
  endtask

  task automatic t_simul();
    do_reset();
    in_valid = 1'b1; in_data = 8'h10;
    tick();
    in_data = 8'h11;
    tick();
    out_ready = 1'b1;
    for (int i = 0; i < 6; i++) begin
      chk(out_data == 8'(8'h10 + i), "R11 order", out_data, 8'h10 + i);
      in_data = 8'(8'h12 + i);
      tick();
    end
    in_valid = 1'b0;
    chk(out_data == 8'h16, "R11 count kept", out_data, 8'h16);
    tick();
    chk(out_data == 8'h17 && out_valid, "R11 last", out_data, 8'h17);
    tick();
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R11 drained", out_valid, 0);
  endtask

  task automatic t_trace();
    do_reset();
    trace_empty = 1'b0;
    tick();
    chk(busy_level == 1'b1, "R7 busy from trace", busy_level, 1);
    tick();
    chk(busy_level == 1'b1, "R7 busy held", busy_level, 1);
    trace_empty = 1'b1;
    tick();
    chk(busy_level == 1'b0, "R9 ready after trace", busy_level, 0);
  endtask

  task automatic t_debug();
    do_reset();
    debug_active = 1'b1;
    tick();
    chk(busy_level == 1'b1, "R8 busy from debug", busy_level, 1);
    tick();
    chk(out_valid == 1'b0, "R8 queue empty", out_valid, 0);
    debug_active = 1'b0;
    tick();
    chk(busy_level == 1'b0, "R9 ready after debug", busy_level, 0);
  endtask

  initial begin
    t_reset();
    t_order();
    t_hold();
    t_full();
    t_simul();
    t_trace();
    t_debug();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule